// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A caller presents an 18-bit base address together with one of two address strobes, one meant for a processor port and one for a memory controller port. Either strobe captures the base. After that, each clock edge that sees the advance input asserted moves the burst forward by one beat. Only the two lowest address bits take part in the burst, so a burst is four beats long and then wraps back to its first address. The upper bits keep the captured value for the whole burst.

A mode input chooses between two four-beat orders. The linear order adds the beat number to the start offset, modulo four. The interleaved order combines the beat number with the start offset by XOR. If the advance input is deasserted, the burst pauses and the current address is reused. A new strobe can be applied on any beat; it drops the burst in progress and starts a new one from the new base. When a strobe and the advance input arrive together, the strobe takes precedence.

Internally, a two-bit beat counter is cleared on each load. The output offset is computed from that counter, the stored start offset and the present level of the mode input.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, the output address is all zeros.
- R2: When `procStrobe` or `ctrlStrobe` is high at a rising edge, the output equals `baseAddrIn` after that edge, for every start offset and either mode.
- R3: With `interleaveMode` low, beat k (k = 0..3) has low bits (start + k) mod 4. Example: a start of 2 gives 2, 3, 0, 1.
- R4: With `interleaveMode` high, beat k has low bits start XOR k. Example: a start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R5: A rising edge with `advance` low and no strobe leaves the output address unchanged.
- R6: After four advancing edges, the output returns to the address that was loaded.
- R7: A strobe that arrives while a burst is in progress has priority over `advance`. Its edge restarts the burst at the new base, and the following advances step from that new base.
- R8: During a burst, output bits 17..2 stay equal to bits 17..2 of the loaded base.
- R9: The mode input acts combinationally on the current beat. Changing it in the middle of a burst changes the output offset at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| procStrobe | input | 1 | Processor-side address strobe; loads the base |
| ctrlStrobe | input | 1 | Controller-side address strobe; loads the base |
| advance | input | 1 | High steps the burst by one beat; low holds it |
| interleaveMode | input | 1 | 0 selects the linear order, 1 selects the XOR order |
| baseAddrIn | input | 18 | External base address |
| burstAddr | output | 18 | Current burst address |

## Verification
Every one of the four start offsets is run through a full four-beat burst in both modes, and the two strobes are used alternately. This separates adding the beat number from XORing it: the two orders agree on starts 0 and 2 for the first beats and disagree on starts 1 and 3, so both kinds of start are needed. A paused burst shows that holding is distinct from stepping. A strobe issued with `advance` held high, in the middle of a burst, shows that loading wins over stepping. Base addresses whose upper bits differ from any earlier value reveal upper bits that leak or go stale, and a mode flip between edges shows that the order is chosen from the live mode input rather than a latched copy.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int ADDR_W = 18;
  localparam int OFFS_W = 2;

  typedef struct packed {
    logic loadBase;
    logic stepBeat;
  } seqCtrl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic     procStrobe,
  input  logic     ctrlStrobe,
  input  logic     advance,
  output seqCtrl_t ctrlOut
);
  logic anyStrobe;

  // a strobe on either port wins over advance
  always_comb begin
    anyStrobe        = procStrobe | ctrlStrobe;
    ctrlOut.loadBase = anyStrobe;
    ctrlOut.stepBeat = advance & ~anyStrobe;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  seqCtrl_t      ctrlIn,
  input  logic          interleaveMode,
  input  logic [AW-1:0] baseAddrIn,
  output logic [AW-1:0] burstAddr
);
  localparam int HI_W = AW - OW;

  logic [AW-1:0] baseReg;
  logic [OW-1:0] beatCnt;
  logic [OW-1:0] startOffs;
  logic [OW-1:0] lowOffs;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      beatCnt <= '0;
    end else if (ctrlIn.loadBase) begin
      baseReg <= baseAddrIn;
      beatCnt <= '0;
    end else if (ctrlIn.stepBeat) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    startOffs = baseReg[OW-1:0];
    if (interleaveMode) lowOffs = startOffs ^ beatCnt;
    else                lowOffs = startOffs + beatCnt;
    burstAddr = {baseReg[AW-1:OW], lowOffs};
  end

  // R2 / R7: a load presents the new base on the next cycle
  assert_load_base_R2: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.loadBase |=> burstAddr == $past(baseAddrIn));

  // R8: upper bits do not move without a load
  assert_upper_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrlIn.loadBase |=> burstAddr[AW-1:OW] == $past(burstAddr[AW-1:OW]));

  // R3 / R6: each step moves the beat by exactly one, wrapping modulo four
  assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.stepBeat |=> beatCnt == OW'($past(beatCnt) + 1'b1));

  // R5: with neither load nor step the beat holds
  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrlIn.loadBase && !ctrlIn.stepBeat) |=> beatCnt == $past(beatCnt));

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] baseAddrIn,
  output logic [ADDR_W-1:0] burstAddr
);
  seqCtrl_t seqCtrl;

  burst_seq_ctrl u_ctrl (
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .ctrlOut    (seqCtrl)
  );

  burst_seq_dp #(.AW(ADDR_W), .OW(OFFS_W)) u_dp (
    .clk            (clk),
    .rst            (rst),
    .ctrlIn         (seqCtrl),
    .interleaveMode (interleaveMode),
    .baseAddrIn     (baseAddrIn),
    .burstAddr      (burstAddr)
  );
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        procStrobe = 1'b0;
  logic        ctrlStrobe = 1'b0;
  logic        advance = 1'b0;
  logic        interleaveMode = 1'b0;
  logic [17:0] baseAddrIn = '0;
  logic [17:0] burstAddr;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst(rst), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .advance(advance), .interleaveMode(interleaveMode),
    .baseAddrIn(baseAddrIn), .burstAddr(burstAddr)
  );

  function automatic logic [17:0] expAddr(input logic [17:0] base,
                                          input int k, input logic ilv);
    logic [1:0] kk;
    kk = 2'(k);
    return {base[17:2], ilv ? (base[1:0] ^ kk) : 2'(base[1:0] + kk)};
  endfunction

  task automatic chk(input logic [17:0] exp, input string tag);
    testsRun++;
    if (burstAddr !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, burstAddr, exp);
    end
  endtask

  // drive away from the edge, then sample 1 ns after it
  task automatic edgeWith(input logic p, input logic c, input logic adv,
                          input logic [17:0] base);
    procStrobe = p; ctrlStrobe = c; advance = adv; baseAddrIn = base;
    @(posedge clk); #1;
    procStrobe = 0; ctrlStrobe = 0; advance = 0;
  endtask

  task automatic runBurst(input logic [17:0] base, input logic ilv,
                          input logic useProc, input string tag);
    interleaveMode = ilv;
    edgeWith(useProc, !useProc, 1'b0, base);
    chk(base, {tag, " R2 load"});
    for (int k = 1; k <= 4; k++) begin
      edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
      if (k == 4) chk(base, {tag, " R6 wrap"});
      else chk(expAddr(base, k, ilv), {tag, ilv ? " R4 interleave" : " R3 linear", " R8"});
    end
  endtask

  task automatic testReset();
    edgeWith(1'b1, 1'b0, 1'b0, 18'h3FFFF);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(18'h0, "R1 reset");
  endtask

  task automatic testSuspend();
    logic [17:0] b;
    b = 18'h15432;
    interleaveMode = 0;
    edgeWith(1'b1, 1'b0, 1'b0, b);
    edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
    edgeWith(1'b0, 1'b0, 1'b0, 18'h3FFFF);
    chk(expAddr(b, 1, 0), "R5 hold 1");
    edgeWith(1'b0, 1'b0, 1'b0, 18'h0);
    chk(expAddr(b, 1, 0), "R5 hold 2");
    edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
    chk(expAddr(b, 2, 0), "R5 resume");
  endtask

  task automatic testRestart();
    logic [17:0] b1, b2;
    b1 = 18'h0ABC1; b2 = 18'h2F0F3;
    interleaveMode = 1;
    edgeWith(1'b0, 1'b1, 1'b0, b1);
    edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
    edgeWith(1'b1, 1'b0, 1'b1, b2);
    chk(b2, "R7 restart beats advance");
    edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
    chk(expAddr(b2, 1, 1), "R7 step after restart");
    edgeWith(1'b0, 1'b1, 1'b1, b1);
    chk(b1, "R7 controller strobe restart");
  endtask

  task automatic testModeSwitch();
    logic [17:0] b;
    b = 18'h30001;
    interleaveMode = 0;
    edgeWith(1'b1, 1'b0, 1'b0, b);
    edgeWith(1'b0, 1'b0, 1'b1, 18'h0);
    chk(expAddr(b, 1, 0), "R9 linear beat1");
    interleaveMode = 1; #1;
    chk(expAddr(b, 1, 1), "R9 switch to interleave");
    interleaveMode = 0; #1;
    chk(expAddr(b, 1, 0), "R9 switch back");
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(18'h0, "R1 after reset");
    for (int s = 0; s < 4; s++) begin
      runBurst({16'hA5C3 + 16'(s), 2'(s)}, 1'b0, s[0], "lin");
      runBurst({16'h1E70 - 16'(s), 2'(s)}, 1'b1, !s[0], "ilv");
    end
    testSuspend();
    testRestart();
    testModeSwitch();
    testReset();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule